// File: doc/BRIEF.md
# Packed Word Insert Unit

This SIMD execution unit writes one 16-bit word into a chosen lane of a packed vector and returns the updated vector. The caller supplies a vector, a 32-bit scalar (or a 16-bit memory value that has been zero- or sign-extended), an 8-bit immediate that picks the lane, a two-bit mode code and a vector-length bit. The unit registers the result and presents it through a valid/ready handshake one cycle after it accepts the operands.

Three modes are supported. The narrow mode edits a 64-bit packed register in place. The wide mode edits the low 128 bits of a register in place. The three-operand mode copies a 128-bit first source, replaces one lane, and clears every bit from 128 upward. The three-operand mode faults when the length bit is set, and the reserved mode code always faults. A faulting operation returns an all-zero vector with the fault flag raised, which tells the consumer to suppress the register write. The unit has no status-flag or numeric-exception outputs.

Top module: `wins_unit`

## Requirements
- R1: Only bits [15:0] of `src_in` are written into the vector. Bits [31:16] have no effect on the result.
- R2: In mode 2'b00 (narrow), the lane is `imm_in[1:0]`, which selects one of lanes 0 to 3. Bits [7:2] of the immediate are ignored.
- R3: In mode 2'b01 (wide), the lane is `imm_in[2:0]`, which selects one of lanes 0 to 7. Bits [7:3] of the immediate are ignored.
- R4: In modes 2'b00 and 2'b01, every bit of `vec_in` outside the selected lane reaches `out_vec` unchanged, including bits [255:128].
- R5: In mode 2'b10 (three-operand) with `vl_in` = 0, the result is `vec_in[127:0]` with lane `imm_in[2:0]` replaced. Bits [255:128] are zero and `out_fault` is 0.
- R6: In mode 2'b10 with `vl_in` = 1, the unit sets `out_fault` = 1 and drives `out_vec` to zero. In modes 2'b00 and 2'b01, `vl_in` has no effect.
- R7: Mode 2'b11 is reserved. It sets `out_fault` = 1 and drives `out_vec` to zero.
- R8: Lane n occupies bits [16n+15:16n], and lane 0 is the least significant.
- R9: Operands are taken when `in_valid` and `in_ready` are both high. The result and fault flag appear with `out_valid` after the next rising edge. While `out_valid` is high and `out_ready` is low, the outputs hold steady and `in_ready` is low. Otherwise `in_ready` is high.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Unit can take operands |
| vec_in | input | 256 | Destination vector (in-place modes) or first source (three-operand mode) |
| src_in | input | 32 | Scalar source; only the low word is used |
| imm_in | input | 8 | Lane-select immediate |
| mode_in | input | 2 | 00 narrow, 01 wide, 10 three-operand, 11 reserved |
| vl_in | input | 1 | Vector-length bit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 256 | Updated vector, or zero on a fault |
| out_fault | output | 1 | Invalid-opcode flag |

## Verification
The bench drives immediates whose upper bits are all set, so a unit that reads too many index bits would pick a lane beyond 3 in narrow mode, or beyond 7 in wide mode. It sets the scalar's upper half to a pattern unlike its low word, which exposes a unit that inserts the wrong half of the source. It runs the three-operand mode with a nonzero upper half in `vec_in`. A unit that forgot to clear those bits would leak them, and a unit that cleared them in wide mode would destroy them. It also sets the length bit in every mode, applies back-pressure while a result is held, and resets during a hold. These cases catch a misplaced fault condition, a result that changes while stalled, and a reset that leaves a stale result visible.

// File: rtl/wins_pkg.sv
`timescale 1ns/1ps
package wins_pkg;
   typedef enum logic [1:0] {
      WM_NARROW = 2'b00,
      WM_WIDE   = 2'b01,
      WM_THREE  = 2'b10,
      WM_RSVD   = 2'b11
   } wins_mode_e;
endpackage

// File: rtl/wins_lane_sel.sv
`timescale 1ns/1ps
module wins_lane_sel
   import wins_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int NARROW_W = 64,
   parameter int MID_W    = 128,
   parameter int IMM_W    = 8,
   localparam int M_LANES = MID_W / WORD_W
) (
   input  logic [1:0]         mode,
   input  logic [IMM_W-1:0]   imm,
   input  logic               vl,
   output logic [M_LANES-1:0] lane_hot,
   output logic               fault,
   output logic               zero_upper
);
   localparam int N_LANES = NARROW_W / WORD_W;
   localparam int N_SW    = $clog2(N_LANES);
   localparam int M_SW    = $clog2(M_LANES);

   logic [M_SW-1:0] idx;
   logic            unused_imm;

   assign unused_imm = ^imm[IMM_W-1:M_SW];

   always_comb begin
      idx        = '0;
      fault      = 1'b0;
      zero_upper = 1'b0;
      unique case (wins_mode_e'(mode))
         WM_NARROW: idx = {{(M_SW-N_SW){1'b0}}, imm[N_SW-1:0]};
         WM_WIDE:   idx = imm[M_SW-1:0];
         WM_THREE: begin
            idx        = imm[M_SW-1:0];
            zero_upper = 1'b1;
            fault      = vl;
         end
         default:   fault = 1'b1;
      endcase
   end

   for (genvar i = 0; i < M_LANES; i++) begin : g_hot
      assign lane_hot[i] = !fault && (idx == M_SW'(i));
   end
endmodule

// File: rtl/wins_merge.sv
`timescale 1ns/1ps
module wins_merge #(
   parameter int VEC_W    = 256,
   parameter int WORD_W   = 16,
   parameter int MID_W    = 128,
   localparam int M_LANES = MID_W / WORD_W
) (
   input  logic [VEC_W-1:0]   base,
   input  logic [WORD_W-1:0]  word,
   input  logic [M_LANES-1:0] lane_hot,
   input  logic               zero_upper,
   input  logic               fault,
   output logic [VEC_W-1:0]   merged
);
   logic [VEC_W-1:0] spliced;

   for (genvar i = 0; i < M_LANES; i++) begin : g_lane
      assign spliced[i*WORD_W +: WORD_W] =
         lane_hot[i] ? word : base[i*WORD_W +: WORD_W];
   end

   if (VEC_W > MID_W) begin : g_upper
      assign spliced[VEC_W-1:MID_W] = zero_upper ? '0 : base[VEC_W-1:MID_W];
   end

   assign merged = fault ? '0 : spliced;
endmodule

// File: rtl/wins_hold_reg.sv
`timescale 1ns/1ps
module wins_hold_reg #(
   parameter int DW = 256
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] vec_d,
   input  logic          fault_d,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] vec_q,
   output logic          fault_q
);
   logic take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         fault_q   <= 1'b0;
      end else if (take) begin
         out_valid <= 1'b1;
         fault_q   <= fault_d;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (take) vec_q <= vec_d;
   end
endmodule

// File: rtl/wins_unit.sv
`timescale 1ns/1ps
module wins_unit #(
   parameter int VEC_W    = 256,
   parameter int MID_W    = 128,
   parameter int NARROW_W = 64,
   parameter int WORD_W   = 16,
   parameter int SRC_W    = 32,
   parameter int IMM_W    = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [VEC_W-1:0] vec_in,
   input  logic [SRC_W-1:0] src_in,
   input  logic [IMM_W-1:0] imm_in,
   input  logic [1:0]       mode_in,
   input  logic             vl_in,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [VEC_W-1:0] out_vec,
   output logic             out_fault
);
   localparam int M_LANES = MID_W / WORD_W;

   if (VEC_W <= MID_W) begin : g_bad_vec
      $error("VEC_W must exceed MID_W");
   end
   if (MID_W <= NARROW_W || (MID_W % WORD_W) != 0 || (NARROW_W % WORD_W) != 0) begin : g_bad_mid
      $error("lane widths must divide the register widths and MID_W must exceed NARROW_W");
   end
   if (SRC_W <= WORD_W || (1 << IMM_W) < M_LANES) begin : g_bad_src
      $error("source or immediate too narrow");
   end

   logic [M_LANES-1:0] lane_hot;
   logic               fault_d;
   logic               zero_upper;
   logic [VEC_W-1:0]   merged;
   logic               unused_src;

   assign unused_src = ^src_in[SRC_W-1:WORD_W];

   wins_lane_sel #(
      .WORD_W(WORD_W), .NARROW_W(NARROW_W), .MID_W(MID_W), .IMM_W(IMM_W)
   ) u_sel (
      .mode(mode_in), .imm(imm_in), .vl(vl_in),
      .lane_hot(lane_hot), .fault(fault_d), .zero_upper(zero_upper)
   );

   wins_merge #(
      .VEC_W(VEC_W), .WORD_W(WORD_W), .MID_W(MID_W)
   ) u_merge (
      .base(vec_in), .word(src_in[WORD_W-1:0]), .lane_hot(lane_hot),
      .zero_upper(zero_upper), .fault(fault_d), .merged(merged)
   );

   wins_hold_reg #(.DW(VEC_W)) u_hold (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .vec_d(merged), .fault_d(fault_d), .out_valid(out_valid),
      .out_ready(out_ready), .vec_q(out_vec), .fault_q(out_fault)
   );
endmodule

// File: rtl/wins_chk.sv
`timescale 1ns/1ps
module wins_chk #(
   parameter int VEC_W = 256,
   parameter int MID_W = 128
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic [VEC_W-1:0] vec_in,
   input logic [1:0]       mode_in,
   input logic             vl_in,
   input logic             out_valid,
   input logic             out_ready,
   input logic [VEC_W-1:0] out_vec,
   input logic             out_fault
);
   logic acc;
   assign acc = in_valid && in_ready;

   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_vec) && $stable(out_fault));
   a_r9_stall: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready);
   a_r9_accept: assert property (@(posedge clk) disable iff (rst)
      acc |=> out_valid);
   a_r6_vl_fault: assert property (@(posedge clk) disable iff (rst)
      acc && mode_in == 2'b10 && vl_in |=> out_fault);
   a_r7_rsvd: assert property (@(posedge clk) disable iff (rst)
      acc && mode_in == 2'b11 |=> out_fault);
   a_r6_zero: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_fault |-> out_vec == '0);
   a_r5_upper: assert property (@(posedge clk) disable iff (rst)
      acc && mode_in == 2'b10 && !vl_in |=> !out_fault && out_vec[VEC_W-1:MID_W] == '0);
   a_r4_upper: assert property (@(posedge clk) disable iff (rst)
      acc && !mode_in[1] |=> !out_fault && out_vec[VEC_W-1:MID_W] == $past(vec_in[VEC_W-1:MID_W]));
   a_r10_reset: assert property (@(posedge clk)
      rst |=> !out_valid && !out_fault);
endmodule

bind wins_unit wins_chk #(.VEC_W(VEC_W), .MID_W(MID_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .vec_in(vec_in), .mode_in(mode_in), .vl_in(vl_in),
   .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
   .out_fault(out_fault)
);

// File: tb/sim_wins_unit.sv
`timescale 1ns/1ps
module sim_wins_unit;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic         in_ready;
   logic [255:0] vec_in;
   logic [31:0]  src_in;
   logic [7:0]   imm_in;
   logic [1:0]   mode_in;
   logic         vl_in;
   logic         out_valid;
   logic         out_ready;
   logic [255:0] out_vec;
   logic         out_fault;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   wins_unit u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .vec_in(vec_in), .src_in(src_in), .imm_in(imm_in), .mode_in(mode_in),
      .vl_in(vl_in), .out_valid(out_valid), .out_ready(out_ready),
      .out_vec(out_vec), .out_fault(out_fault)
   );

   function automatic logic exp_fault(logic [1:0] m, logic vl);
      return (m == 2'b11) || (m == 2'b10 && vl);
   endfunction

   function automatic logic [255:0] exp_vec(logic [255:0] v, logic [31:0] s,
                                             logic [7:0] imm, logic [1:0] m, logic vl);
      logic [255:0] r;
      int lane;
      if (exp_fault(m, vl)) return '0;
      r = v;
      if (m == 2'b10) r[255:128] = '0;
      lane = (m == 2'b00) ? int'(imm[1:0]) : int'(imm[2:0]);
      r[lane*16 +: 16] = s[15:0];
      return r;
   endfunction

   task automatic chk_vec(string req, logic [255:0] act, logic [255:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s vec act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_bit(string req, string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
      end
   endtask

   function automatic logic [255:0] rand_vec();
      logic [255:0] v;
      for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   // Issue one operation with out_ready high and check the result.
   task automatic run_op(string req, logic [255:0] v, logic [31:0] s,
                         logic [7:0] imm, logic [1:0] m, logic vl);
      @(negedge clk);
      in_valid = 1'b1; vec_in = v; src_in = s; imm_in = imm; mode_in = m; vl_in = vl;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk_bit(req, "out_valid", out_valid, 1'b1);
      chk_bit(req, "out_fault", out_fault, exp_fault(m, vl));
      chk_vec(req, out_vec, exp_vec(v, s, imm, m, vl));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [255:0] v;
      logic [255:0] held;
      void'($urandom(32'h1d2c));
      rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
      vec_in = '0; src_in = '0; imm_in = '0; mode_in = '0; vl_in = 1'b0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk_bit("R10", "out_valid", out_valid, 1'b0);
      chk_bit("R10", "out_fault", out_fault, 1'b0);
      chk_bit("R9", "in_ready", in_ready, 1'b1);
      rst = 1'b0;

      v = rand_vec();
      // R2 / R1: upper immediate bits set, source upper half differs from low word
      run_op("R2", v, 32'hABCD_1234, 8'hFF, 2'b00, 1'b0);
      run_op("R1", v, 32'hFFFF_0000, 8'h06, 2'b00, 1'b0);
      // R3: imm 0xFD selects lane 5
      run_op("R3", v, 32'h5555_BEEF, 8'hFD, 2'b01, 1'b0);
      // R8: lane 7 and lane 0
      run_op("R8", v, 32'h0000_C0DE, 8'h07, 2'b01, 1'b0);
      run_op("R8", v, 32'h1234_F00D, 8'hF8, 2'b01, 1'b0);
      // R4 / R6: in-place modes keep the upper half and ignore the length bit
      run_op("R4", {128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98, v[127:0]},
             32'h0000_7777, 8'h02, 2'b01, 1'b1);
      run_op("R6", v, 32'h0000_7777, 8'h01, 2'b00, 1'b1);
      // R5: three-operand with nonzero upper half
      run_op("R5", {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, v[127:0]},
             32'h9999_4321, 8'hFC, 2'b10, 1'b0);
      // R6: length bit faults three-operand mode
      run_op("R6", v, 32'h0000_1111, 8'h03, 2'b10, 1'b1);
      // R7: reserved mode faults
      run_op("R7", v, 32'h0000_2222, 8'h00, 2'b11, 1'b0);

      // R9: back-pressure holds the result
      @(negedge clk);
      in_valid = 1'b1; vec_in = v; src_in = 32'h0000_ABAB; imm_in = 8'h04;
      mode_in = 2'b01; vl_in = 1'b0; out_ready = 1'b0;
      @(negedge clk);
      held = exp_vec(v, 32'h0000_ABAB, 8'h04, 2'b01, 1'b0);
      src_in = 32'h0000_0101; imm_in = 8'h00;
      repeat (3) begin
         @(negedge clk);
         chk_bit("R9", "in_ready stalled", in_ready, 1'b0);
         chk_bit("R9", "out_valid held", out_valid, 1'b1);
         chk_vec("R9", out_vec, held);
      end
      in_valid = 1'b0; out_ready = 1'b1;
      @(negedge clk);
      chk_bit("R9", "out_valid drained", out_valid, 1'b0);

      // R10: reset during a held fault result
      @(negedge clk);
      in_valid = 1'b1; mode_in = 2'b11; out_ready = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      chk_bit("R7", "out_fault", out_fault, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk_bit("R10", "out_valid", out_valid, 1'b0);
      chk_bit("R10", "out_fault", out_fault, 1'b0);
      out_ready = 1'b1;

      // Random mix over all modes (R1..R8)
      for (int n = 0; n < 400; n++) begin
         run_op("R1-mix", rand_vec(), $urandom, 8'($urandom),
                2'($urandom), 1'($urandom));
      end
      finish_run();
   end
endmodule